// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This core is the timing engine of a watchdog that gives software two chances before a reboot. When the watchdog is switched on, or when software sends a keep-alive, the core loads the first interval and counts it down. If that interval runs out, the core raises a one-cycle interrupt of the selected kind. It then counts a second interval, loaded from its own preload. If the second interval also runs out, the core either requests a system reboot and records that it did so, or, when free-running operation is chosen, starts the first interval again.

Intervals are counted in ticks of a prescaled reference clock. A rate select picks either a slow tick (2^SLOW_LOG2 reference cycles per count) or a fast tick (2^FAST_LOG2 cycles per count). A stage with preload P lasts (P+1) ticks. Register decode, unlock sequences and the reset action itself belong to the surrounding logic.

Top module: `wdg_core`

## Requirements
- R1: A 0-to-1 change of `enable`, sampled at a clock edge E, loads `preload1` and puts the core in stage 1; with preload P1 and tick length T, stage 1 ends at edge E + (P1+1)*T.
- R2: At the end of stage 1 the core emits a one-cycle pulse chosen by `int_type` (2'b00 pulses `irq_pulse`, 2'b10 pulses `smi_pulse`, 2'b01 and 2'b11 pulse nothing), enters stage 2 and loads `preload2`; stage 2 with preload P2 ends (P2+1)*T cycles later.
- R3: When stage 2 ends with `reboot_en` high, `reboot_req` pulses for one cycle, `reboot_flag` is set and stays set until reset, and the core goes idle.
- R4: When stage 2 ends with `reboot_en` low and `free_run` high, the core re-enters stage 1 from `preload1` without any reboot request.
- R5: When stage 2 ends with both `reboot_en` and `free_run` low, the core goes idle and pulses nothing.
- R6: With `enable` low the core is idle one edge later, produces no pulse afterwards, and ignores `restart`.
- R7: A `restart` pulse while enabled reloads `preload1`, clears the prescaler and returns to stage 1; it wins over a stage expiry due at the same edge.
- R8: `rate_fast` high makes T = 2^FAST_LOG2 reference cycles; low makes T = 2^SLOW_LOG2.
- R9: `stage` reads 0 when idle, 1 in stage 1, 2 in stage 2; after reset `stage` is 0 and all pulse outputs and `reboot_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Watchdog on; rising edge starts stage 1 |
| restart | input | 1 | Keep-alive pulse |
| preload1 | input | CNT_W | Stage-1 interval in ticks minus one |
| preload2 | input | CNT_W | Stage-2 interval in ticks minus one |
| rate_fast | input | 1 | 1 selects the fast tick, 0 the slow tick |
| int_type | input | 2 | Stage-1 expiry action: 00 IRQ, 10 SMI, others none |
| reboot_en | input | 1 | Stage-2 expiry requests a reboot |
| free_run | input | 1 | Stage-2 expiry restarts stage 1 when reboot is off |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| smi_pulse | output | 1 | One-cycle system-management pulse |
| reboot_req | output | 1 | One-cycle reboot request |
| reboot_flag | output | 1 | Sticky record of a watchdog reboot |
| stage | output | 2 | 0 idle, 1 stage 1, 2 stage 2 |

## Verification
The countdown is driven through each stage-2 outcome (reboot, free-run loop, plain stop), which separates the three end-of-stage branches, and through each interrupt type, which shows the pulse routing. Both tick rates are used with different preloads so that an off-by-one in the tick length or the preload count moves a pulse to the wrong cycle. Keep-alives are sent mid-interval and exactly on the expiry edge, telling a correct reload apart from one that loses to the expiry, and a disable followed by a long quiet window plus a keep-alive while disabled shows that nothing leaks out once off.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2
    } wdg_stage_e;

    localparam logic [1:0] ITYPE_IRQ = 2'b00;
    localparam logic [1:0] ITYPE_SMI = 2'b10;

    typedef struct packed {
        logic irq;
        logic smi;
        logic reboot;
    } wdg_fire_t;

    function automatic wdg_fire_t stage1_fire(input logic [1:0] itype);
        wdg_fire_t f;
        f.irq    = (itype == ITYPE_IRQ);
        f.smi    = (itype == ITYPE_SMI);
        f.reboot = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
    parameter int SLOW_LOG2 = 15,
    parameter int FAST_LOG2 = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clear,
    input  logic rate_fast,
    output logic tick
);
    localparam int W = ((SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2) + 1;
    localparam logic [W-1:0] MASK_SLOW = W'((64'd1 << SLOW_LOG2) - 64'd1);
    localparam logic [W-1:0] MASK_FAST = W'((64'd1 << FAST_LOG2) - 64'd1);

    logic [W-1:0] pre_q;
    logic [W-1:0] limit;

    assign limit = rate_fast ? MASK_FAST : MASK_SLOW;
    // >= so that a rate change mid-count cannot strand the counter above the limit
    assign tick  = run && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear || !run || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    assign zero = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && !zero)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int SLOW_LOG2 = 15,
    parameter int FAST_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             restart,
    input  logic [CNT_W-1:0] preload1,
    input  logic [CNT_W-1:0] preload2,
    input  logic             rate_fast,
    input  logic [1:0]       int_type,
    input  logic             reboot_en,
    input  logic             free_run,
    output logic             irq_pulse,
    output logic             smi_pulse,
    output logic             reboot_req,
    output logic             reboot_flag,
    output logic [1:0]       stage
);
    wdg_stage_e       stage_q, stage_d;
    logic             en_q;
    logic             start, expire, tick, cnt_zero, running;
    logic             load, dec, clr_pre;
    logic [CNT_W-1:0] load_val;
    wdg_fire_t        fire_d, fire_q;

    assign running = (stage_q != ST_IDLE);
    assign start   = enable && (restart || !en_q);
    assign expire  = running && tick && cnt_zero;

    wdg_tick_gen #(
        .SLOW_LOG2 (SLOW_LOG2),
        .FAST_LOG2 (FAST_LOG2)
    ) u_tick (
        .clk       (clk),
        .rst       (rst),
        .run       (running),
        .clear     (clr_pre),
        .rate_fast (rate_fast),
        .tick      (tick)
    );

    wdg_down_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .zero     (cnt_zero)
    );

    // priority: disable, then start/keep-alive, then expiry, then plain tick
    always_comb begin
        stage_d  = stage_q;
        load     = 1'b0;
        load_val = preload1;
        dec      = 1'b0;
        clr_pre  = 1'b0;
        fire_d   = '0;
        if (!enable) begin
            stage_d = ST_IDLE;
            clr_pre = 1'b1;
        end else if (start) begin
            stage_d = ST_ONE;
            load    = 1'b1;
            clr_pre = 1'b1;
        end else if (expire) begin
            clr_pre = 1'b1;
            if (stage_q == ST_ONE) begin
                stage_d  = ST_TWO;
                load     = 1'b1;
                load_val = preload2;
                fire_d   = stage1_fire(int_type);
            end else if (reboot_en) begin
                stage_d       = ST_IDLE;
                fire_d.reboot = 1'b1;
            end else if (free_run) begin
                stage_d = ST_ONE;
                load    = 1'b1;
            end else begin
                stage_d = ST_IDLE;
            end
        end else if (tick) begin
            dec = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q     <= ST_IDLE;
            en_q        <= 1'b0;
            fire_q      <= '0;
            reboot_flag <= 1'b0;
        end else begin
            stage_q <= stage_d;
            en_q    <= enable;
            fire_q  <= fire_d;
            if (fire_d.reboot)
                reboot_flag <= 1'b1;
        end
    end

    assign irq_pulse  = fire_q.irq;
    assign smi_pulse  = fire_q.smi;
    assign reboot_req = fire_q.reboot;
    assign stage      = stage_q;
endmodule

// File: rtl/wdg_core_chk.sv
module wdg_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       restart,
    input logic       irq_pulse,
    input logic       smi_pulse,
    input logic       reboot_req,
    input logic       reboot_flag,
    input logic [1:0] stage
);
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $countones({irq_pulse, smi_pulse, reboot_req}) <= 1); // R2

    AST_INT_FROM_STAGE1: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || smi_pulse) |-> (stage == 2'd2)); // R2

    AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || smi_pulse) |=> !(irq_pulse || smi_pulse)); // R2

    AST_REBOOT_IDLE: assert property (@(posedge clk) disable iff (rst)
        reboot_req |-> (reboot_flag && stage == 2'd0)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        reboot_flag |=> reboot_flag); // R3

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (stage == 2'd0 && !irq_pulse && !smi_pulse && !reboot_req)); // R6

    AST_RESTART_STAGE1: assert property (@(posedge clk) disable iff (rst)
        (enable && restart) |=> (stage == 2'd1)); // R7

    AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        stage != 2'd3); // R9
endmodule

bind wdg_core wdg_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .restart     (restart),
    .irq_pulse   (irq_pulse),
    .smi_pulse   (smi_pulse),
    .reboot_req  (reboot_req),
    .reboot_flag (reboot_flag),
    .stage       (stage)
);

// File: tb/wdg_core_tb.sv
module wdg_core_tb;
    localparam int CNT_W = 20;
    localparam int SLOW  = 4;
    localparam int FAST  = 2;
    localparam int TS    = 1 << SLOW;
    localparam int TF    = 1 << FAST;

    localparam int K_IRQ = 0;
    localparam int K_SMI = 1;
    localparam int K_RB  = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic             restart = 1'b0;
    logic [CNT_W-1:0] preload1 = '0;
    logic [CNT_W-1:0] preload2 = '0;
    logic             rate_fast = 1'b1;
    logic [1:0]       int_type = 2'b00;
    logic             reboot_en = 1'b0;
    logic             free_run = 1'b0;
    logic             irq_pulse, smi_pulse, reboot_req, reboot_flag;
    logic [1:0]       stage;

    int cyc = 0;
    int checks = 0;
    int failures = 0;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } ev_t;
    ev_t exp_q[$];

    wdg_core #(.CNT_W(CNT_W), .SLOW_LOG2(SLOW), .FAST_LOG2(FAST)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .restart(restart),
        .preload1(preload1), .preload2(preload2), .rate_fast(rate_fast),
        .int_type(int_type), .reboot_en(reboot_en), .free_run(free_run),
        .irq_pulse(irq_pulse), .smi_pulse(smi_pulse), .reboot_req(reboot_req),
        .reboot_flag(reboot_flag), .stage(stage)
    );

    always #5ns clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, expv);
        end
    endtask

    task automatic expect_ev(input int kind, input int at, input string req);
        ev_t e;
        e.kind = kind; e.at = at; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // monitor: every observed pulse must match the head of the queue
    task automatic see(input int kind);
        if (exp_q.size() == 0) begin
            chk("unexpected-pulse", kind, -1);
        end else begin
            chk(exp_q[0].req, kind, exp_q[0].kind);
            chk(exp_q[0].req, cyc, exp_q[0].at);
            void'(exp_q.pop_front());
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                chk({exp_q[0].req, "-missed"}, cyc, exp_q[0].at);
                void'(exp_q.pop_front());
            end
            if (irq_pulse)  see(K_IRQ);
            if (smi_pulse)  see(K_SMI);
            if (reboot_req) see(K_RB);
        end
    end

    task automatic turn_off();
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #200us;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9 stage", int'(stage), 0);
        chk("R9 irq", int'(irq_pulse), 0);
        chk("R9 smi", int'(smi_pulse), 0);
        chk("R9 reboot_req", int'(reboot_req), 0);
        chk("R9 flag", int'(reboot_flag), 0);

        // R1 R2 R3 R8: IRQ, fast rate, reboot
        preload1 = 2; preload2 = 1; rate_fast = 1'b1; int_type = 2'b00;
        reboot_en = 1'b1; free_run = 1'b0;
        e = cyc + 1; enable = 1'b1;
        expect_ev(K_IRQ, e + 3*TF, "R1/R2 irq");
        expect_ev(K_RB,  e + 3*TF + 2*TF, "R3 reboot");
        wait_cyc(e + 1);
        chk("R1 stage1", int'(stage), 1);
        wait_cyc(e + 3*TF);
        chk("R2 stage2", int'(stage), 2);
        wait_cyc(e + 5*TF);
        chk("R3 idle", int'(stage), 0);
        chk("R3 flag", int'(reboot_flag), 1);
        wait_cyc(e + 5*TF + 10);
        chk("R3 flag sticky", int'(reboot_flag), 1);
        turn_off();

        // R4 R8: SMI, slow rate, free-run loop, then R6 disable
        preload1 = 1; preload2 = 0; rate_fast = 1'b0; int_type = 2'b10;
        reboot_en = 1'b0; free_run = 1'b1;
        e = cyc + 1; enable = 1'b1;
        expect_ev(K_SMI, e + 2*TS, "R8/R2 smi");
        expect_ev(K_SMI, e + 2*TS + TS + 2*TS, "R4 smi again");
        wait_cyc(e + 3*TS);
        chk("R4 back to stage1", int'(stage), 1);
        wait_cyc(e + 5*TS + 5);
        enable = 1'b0;
        wait_cyc(e + 5*TS + 6);
        chk("R6 idle", int'(stage), 0);
        repeat (150) @(negedge clk);
        chk("R6 quiet", exp_q.size(), 0);

        // R5 R2: no interrupt type, no reboot, no free-run
        preload1 = 0; preload2 = 0; rate_fast = 1'b1; int_type = 2'b11;
        e = cyc + 1; enable = 1'b1; free_run = 1'b0;
        wait_cyc(e + TF - 1);
        chk("R1 still stage1", int'(stage), 1);
        wait_cyc(e + TF);
        chk("R2 none-type stage2", int'(stage), 2);
        wait_cyc(e + 2*TF);
        chk("R5 idle", int'(stage), 0);
        chk("R5 flag unchanged", int'(reboot_flag), 1);
        repeat (20) @(negedge clk);
        chk("R5 stays idle", int'(stage), 0);
        turn_off();

        // R7: keep-alive mid-interval
        preload1 = 3; preload2 = 5; int_type = 2'b00;
        e = cyc + 1; enable = 1'b1;
        wait_cyc(e + 9);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        expect_ev(K_IRQ, e + 10 + 4*TF, "R7 irq after restart");
        wait_cyc(e + 4*TF);
        chk("R7 no expiry", int'(stage), 1);
        wait_cyc(e + 30);
        turn_off();

        // R7: keep-alive on the expiry edge
        e = cyc + 1; enable = 1'b1;
        wait_cyc(e + 4*TF - 1);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R7 restart wins", int'(stage), 1);
        expect_ev(K_IRQ, e + 8*TF, "R7 irq after tie");
        wait_cyc(e + 8*TF + 2);
        turn_off();

        // R6: restart ignored while disabled
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk("R6 restart ignored", int'(stage), 0);
        repeat (40) @(negedge clk);
        chk("R6 no pending", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule